// File: doc/BRIEF.md
# Synchronous Burst SRAM Controller

This block is the clocked control path of a burst SRAM, with a small behavioural storage array inside it. On every rising clock edge it samples three chip enables, two address strobes, a burst-advance input, the write controls and a sleep request. From these it classifies the cycle as one of the following: a deselect, a burst start (read or write) at the external address, a burst continue to the next address, a burst suspend at the current address, an idle cycle, or a sleep cycle.

One strobe comes from a processor and one from a cache controller. A processor strobe with the first chip enable asserted always starts a read. A write burst can only start from the controller strobe, or take place on a later continue or suspend cycle. The burst address is held in a register whose two low bits count through four words in linear order and wrap around, while the upper bits stay fixed. Read data appears on the cycle after the access. The bus is driven only while the last access was a read and the output enable, which acts without a clock, is low. A sleep request idles the block and turns the bus off. After the request is removed, the block ignores its inputs for a short recovery window.

Top module: `burst_sram_ctl`

## Requirements
- R1: Out of reset, `busDrive` is 0 and `rdData` is all zeros, and no burst is active.
- R2: With `procStrobeN` low and the device selected (`chipEn1N`=0, `chipEn2`=1, `chipEn3N`=0), the cycle reads the word at `addrIn` even when `globalWrN`, `byteWrEnN` and `byteEnN` request a write. The word is on `rdData` after that clock edge.
- R3: The internal write request is active when `globalWrN`=0, or when `byteWrEnN`=0 and at least one `byteEnN` bit is 0. `globalWrN`=0 writes all bytes. Otherwise only the bytes whose `byteEnN` bit is 0 are written, where byte b is `wrData[8b+7:8b]`.
- R4: With `procStrobeN` high, `ctrlStrobeN` low and the device selected, a burst starts at `addrIn`. It is a write when the write request is active and a read otherwise.
- R5: With both strobes high, a burst active and `advN`=0, the access uses the next burst address. The low two bits increment modulo 4 and the upper bits are unchanged. The access is a read or a write according to the write request.
- R6: With both strobes high, a burst active and `advN`=1, the access reuses the current burst address. The access is a read or a write according to the write request.
- R7: When `ctrlStrobeN`=0, or when `procStrobeN`=0 with `chipEn1N`=0, and any chip enable is inactive, the cycle is a deselect. No access takes place, the bus is not driven and the burst ends. Later cycles with both strobes high then access nothing until a new start.
- R8: While `chipEn1N`=1, `procStrobeN` is ignored. With `ctrlStrobeN` high, the cycle behaves as a continue or a suspend.
- R9: `outEnN` acts without a clock. After a read, `busDrive` follows the inverse of `outEnN` at once, and `rdData` is zero while the bus is not driven.
- R10: After a write cycle `busDrive` is 0 whatever the value of `outEnN`.
- R11: On an edge with `sleepReq`=1, no access takes place and the bus is not driven. When `sleepReq` returns to 0, the first edge that samples it low and the next WAKE_CYC-1 edges ignore all inputs. Accesses resume after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| chipEn1N | input | 1 | Chip enable 1, active low; also gates the processor strobe |
| chipEn2 | input | 1 | Chip enable 2, active high |
| chipEn3N | input | 1 | Chip enable 3, active low |
| procStrobeN | input | 1 | Processor address strobe, active low |
| ctrlStrobeN | input | 1 | Controller address strobe, active low |
| advN | input | 1 | Burst advance: 0 continues, 1 suspends |
| globalWrN | input | 1 | Global write, active low, writes every byte |
| byteWrEnN | input | 1 | Byte-write enable, active low |
| byteEnN | input | NB | Per-byte write enables, active low |
| sleepReq | input | 1 | Sleep request, active high |
| outEnN | input | 1 | Output enable, active low, acts without a clock |
| addrIn | input | AW | External word address |
| wrData | input | 8*NB | Write data |
| rdData | output | 8*NB | Read data, zero while the bus is not driven |
| busDrive | output | 1 | High while the data bus is driven |

## Verification
A wrong burst address in this block does not stay hidden. It shows up on `rdData` the cycle after the next read, as a word from the wrong location, so the bench reads back every word of a wrapped burst and each suspend in order. A wrong cycle class shows up differently. A write taken during a deselect, idle or sleep-recovery cycle gives no sign until a later read of the same location, so the bench reads those locations back explicitly. A stuck read flag shows as `busDrive` high right after a write or a sleep edge.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_DESEL,
    CYC_START_RD,
    CYC_START_WR,
    CYC_NEXT,
    CYC_HOLD,
    CYC_SLEEP
  } cycKind_e;

  typedef struct packed {
    logic rdEn;
    logic wrEn;
  } memCtl_t;

endpackage

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
  import bsram_pkg::*;
#(
  parameter int AW       = 6,
  parameter int NB       = 4,
  parameter int WAKE_CYC = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          chipEn1N,
  input  logic          chipEn2,
  input  logic          chipEn3N,
  input  logic          procStrobeN,
  input  logic          ctrlStrobeN,
  input  logic          advN,
  input  logic          globalWrN,
  input  logic          byteWrEnN,
  input  logic [NB-1:0] byteEnN,
  input  logic          sleepReq,
  input  logic [AW-1:0] addrIn,
  output memCtl_t       memCtl,
  output logic [NB-1:0] wrByte,
  output logic [AW-1:0] accAddr
);

  localparam int WCW = $clog2(WAKE_CYC + 1);

  logic [AW-1:0]  burstAddr;
  logic           burstActive;
  logic           asleep;
  logic [WCW-1:0] wakeCnt;
  cycKind_e       kind;
  logic           blocked, selected, procStart, wrReq, isWrite, isRead;

  assign blocked   = sleepReq || asleep || (wakeCnt != '0);
  assign selected  = !chipEn1N && chipEn2 && !chipEn3N;
  assign procStart = !procStrobeN && !chipEn1N;
  assign wrReq     = !globalWrN || (!byteWrEnN && (byteEnN != '1));

  always_comb begin
    if (blocked)             kind = CYC_SLEEP;
    else if (procStart)      kind = selected ? CYC_START_RD : CYC_DESEL;
    else if (!ctrlStrobeN)   kind = !selected ? CYC_DESEL :
                                    (wrReq ? CYC_START_WR : CYC_START_RD);
    else if (burstActive)    kind = advN ? CYC_HOLD : CYC_NEXT;
    else                     kind = CYC_IDLE;
  end

  always_comb begin
    unique case (kind)
      CYC_START_RD, CYC_START_WR: accAddr = addrIn;
      CYC_NEXT: accAddr = {burstAddr[AW-1:2], burstAddr[1:0] + 2'd1};
      default:  accAddr = burstAddr;
    endcase
  end

  assign isWrite = (kind == CYC_START_WR) ||
                   (((kind == CYC_NEXT) || (kind == CYC_HOLD)) && wrReq);
  assign isRead  = (kind == CYC_START_RD) ||
                   (((kind == CYC_NEXT) || (kind == CYC_HOLD)) && !wrReq);

  assign memCtl.rdEn = isRead;
  assign memCtl.wrEn = isWrite;
  assign wrByte = !isWrite ? '0 : (!globalWrN ? '1 : (~byteEnN & {NB{!byteWrEnN}}));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      burstAddr   <= '0;
      burstActive <= 1'b0;
    end else begin
      if (kind == CYC_START_RD || kind == CYC_START_WR || kind == CYC_NEXT)
        burstAddr <= accAddr;
      if (kind == CYC_START_RD || kind == CYC_START_WR)
        burstActive <= 1'b1;
      else if (kind == CYC_DESEL || kind == CYC_SLEEP)
        burstActive <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      asleep  <= 1'b0;
      wakeCnt <= '0;
    end else begin
      asleep <= sleepReq;
      if (sleepReq)           wakeCnt <= '0;
      else if (asleep)        wakeCnt <= WCW'(WAKE_CYC - 1);
      else if (wakeCnt != '0) wakeCnt <= wakeCnt - 1'b1;
    end
  end

  AST_HOLD_SAME_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (kind == CYC_HOLD) |=> (burstAddr == $past(burstAddr))); // R6
  AST_NEXT_WRAPS: assert property (@(posedge clk) disable iff (!rstN)
    (kind == CYC_NEXT) |=> ((burstAddr[1:0] == 2'($past(burstAddr[1:0]) + 2'd1)) &&
                            (burstAddr[AW-1:2] == $past(burstAddr[AW-1:2])))); // R5
  AST_DESEL_ENDS_BURST: assert property (@(posedge clk) disable iff (!rstN)
    (kind == CYC_DESEL) |=> !burstActive); // R7
  AST_PROC_START_READS: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN && !chipEn1N && !blocked) |-> (wrByte == '0)); // R2
  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (asleep || (wakeCnt != '0)) |-> ((wrByte == '0) && !memCtl.rdEn)); // R11

endmodule

// File: rtl/bsram_data.sv
module bsram_data
  import bsram_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  memCtl_t         memCtl,
  input  logic [NB-1:0]   wrByte,
  input  logic [AW-1:0]   accAddr,
  input  logic [8*NB-1:0] wrData,
  input  logic            outEnN,
  output logic [8*NB-1:0] rdData,
  output logic            busDrive
);

  localparam int DW    = 8 * NB;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] wrMask;
  logic [DW-1:0] rdReg;
  logic          readActive;

  for (genvar b = 0; b < NB; b++) begin : g_mask
    assign wrMask[8*b +: 8] = {8{wrByte[b]}};
  end

  always_ff @(posedge clk) begin
    if (memCtl.wrEn)
      mem[accAddr] <= (mem[accAddr] & ~wrMask) | (wrData & wrMask);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readActive <= 1'b0;
      rdReg      <= '0;
    end else begin
      readActive <= memCtl.rdEn;
      if (memCtl.rdEn) rdReg <= mem[accAddr];
    end
  end

  assign busDrive = readActive && !outEnN;
  assign rdData   = busDrive ? rdReg : '0;

  AST_BUS_NEEDS_OE: assert property (@(posedge clk) disable iff (!rstN)
    busDrive |-> !outEnN); // R9
  AST_WRITE_HIDES_BUS: assert property (@(posedge clk) disable iff (!rstN)
    $past(memCtl.wrEn) |-> !busDrive); // R10

endmodule

// File: rtl/burst_sram_ctl.sv
module burst_sram_ctl
  import bsram_pkg::*;
#(
  parameter int AW       = 6,
  parameter int NB       = 4,
  parameter int WAKE_CYC = 2,
  localparam int DW      = 8 * NB
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          chipEn1N,
  input  logic          chipEn2,
  input  logic          chipEn3N,
  input  logic          procStrobeN,
  input  logic          ctrlStrobeN,
  input  logic          advN,
  input  logic          globalWrN,
  input  logic          byteWrEnN,
  input  logic [NB-1:0] byteEnN,
  input  logic          sleepReq,
  input  logic          outEnN,
  input  logic [AW-1:0] addrIn,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  output logic          busDrive
);

  memCtl_t       memCtl;
  logic [NB-1:0] wrByte;
  logic [AW-1:0] accAddr;

  bsram_ctrl #(.AW(AW), .NB(NB), .WAKE_CYC(WAKE_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .chipEn1N(chipEn1N), .chipEn2(chipEn2), .chipEn3N(chipEn3N),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN), .advN(advN),
    .globalWrN(globalWrN), .byteWrEnN(byteWrEnN), .byteEnN(byteEnN),
    .sleepReq(sleepReq), .addrIn(addrIn),
    .memCtl(memCtl), .wrByte(wrByte), .accAddr(accAddr)
  );

  bsram_data #(.AW(AW), .NB(NB)) u_data (
    .clk(clk), .rstN(rstN), .memCtl(memCtl), .wrByte(wrByte),
    .accAddr(accAddr), .wrData(wrData), .outEnN(outEnN),
    .rdData(rdData), .busDrive(busDrive)
  );

endmodule

// File: tb/tb_burst_sram_ctl.sv
module tb_burst_sram_ctl;

  typedef struct packed {
    logic        ce1N, ce2, ce3N, pN, cN, advN, gwN, bweN;
    logic [3:0]  beN;
    logic [5:0]  addr;
    logic [31:0] wdat;
    logic        expDrv;
    logic [31:0] expDat;
    logic [23:0] tag;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    // ce1N ce2 ce3N pN cN advN gwN bweN beN addr wdat expDrv expDat tag
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,6'h0D,32'hA0000001,1'b0,32'h0,"R4 "},
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,4'h0,6'h00,32'hA0000002,1'b0,32'h0,"R10"},
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,4'hF,6'h00,32'hA0000003,1'b0,32'h0,"R5 "},
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,4'hF,6'h00,32'hA0000004,1'b0,32'h0,"R5 "},
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,4'hF,6'h00,32'hB0000004,1'b0,32'h0,"R6 "},
    '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,4'h0,6'h0D,32'hFFFFFFFF,1'b1,32'hA0000001,"R2 "},
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,6'h00,32'h0,1'b1,32'hA0000002,"R5 "},
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,6'h00,32'h0,1'b1,32'hA0000002,"R6 "},
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,6'h00,32'h0,1'b1,32'hA0000003,"R5 "},
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,6'h00,32'h0,1'b1,32'hB0000004,"R5 "},
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,4'hA,6'h0F,32'h11223344,1'b0,32'h0,"R3 "},
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,4'hF,6'h0F,32'hFFFFFFFF,1'b1,32'hA0220044,"R3 "},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,6'h0F,32'h0,1'b0,32'h0,"R7 "},
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,4'hF,6'h0F,32'hDEADBEEF,1'b0,32'h0,"R7 "},
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,6'h0F,32'h0,1'b1,32'hA0220044,"R7 "},
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,6'h0F,32'h0,1'b0,32'h0,"R7 "},
    '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,4'hF,6'h0F,32'h0,1'b0,32'h0,"R7 "},
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,6'h0D,32'h0,1'b1,32'hA0000001,"R4 "},
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,4'hF,6'h00,32'h0,1'b1,32'hA0000002,"R8 "},
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,6'h00,32'h5A5A5A5A,1'b0,32'h0,"R10"},
    '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,4'hF,6'h00,32'h0,1'b1,32'h5A5A5A5A,"R2 "}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chipEn1N = 1'b0, chipEn2 = 1'b1, chipEn3N = 1'b0;
  logic procStrobeN = 1'b1, ctrlStrobeN = 1'b1, advN = 1'b1;
  logic globalWrN = 1'b1, byteWrEnN = 1'b1;
  logic [3:0] byteEnN = 4'hF;
  logic sleepReq = 1'b0, outEnN = 1'b0;
  logic [5:0] addrIn = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic busDrive;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  burst_sram_ctl #(.AW(6), .NB(4), .WAKE_CYC(2)) dut (
    .clk(clk), .rstN(rstN), .chipEn1N(chipEn1N), .chipEn2(chipEn2),
    .chipEn3N(chipEn3N), .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
    .advN(advN), .globalWrN(globalWrN), .byteWrEnN(byteWrEnN),
    .byteEnN(byteEnN), .sleepReq(sleepReq), .outEnN(outEnN), .addrIn(addrIn),
    .wrData(wrData), .rdData(rdData), .busDrive(busDrive)
  );

  task automatic apply(input vec_t v);
    chipEn1N = v.ce1N; chipEn2 = v.ce2; chipEn3N = v.ce3N;
    procStrobeN = v.pN; ctrlStrobeN = v.cN; advN = v.advN;
    globalWrN = v.gwN; byteWrEnN = v.bweN; byteEnN = v.beN;
    addrIn = v.addr; wrData = v.wdat;
  endtask

  task automatic check(input string tag, input logic expDrv, input logic [31:0] expDat);
    checks++;
    if (busDrive !== expDrv || rdData !== expDat) begin
      errors++;
      $display("FAIL %s: busDrive=%0b rdData=%h expected busDrive=%0b rdData=%h",
               tag, busDrive, rdData, expDrv, expDat);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    #1;
  endtask

  // ctrl strobe start helper: write when gw low
  task automatic ctrlStart(input logic [5:0] a, input logic gw, input logic [31:0] d);
    apply('{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,gw,1'b1,4'hF,a,d,1'b0,32'h0,"   "});
  endtask

  initial begin
    repeat (3) cycle();
    check("R1", 1'b0, 32'h0);
    rstN = 1'b1;
    cycle();
    check("R1", 1'b0, 32'h0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      cycle();
      check(string'(VECS[i].tag), VECS[i].expDrv, VECS[i].expDat);
    end

    // R9: output enable acts with no clock edge
    @(negedge clk);
    outEnN = 1'b1;
    #0.5;
    check("R9", 1'b0, 32'h0);
    outEnN = 1'b0;
    #0.5;
    check("R9", 1'b1, 32'h5A5A5A5A);

    // R11: sleep entry, ignored accesses, recovery window
    ctrlStart(6'h0D, 1'b1, 32'h0);
    cycle();
    check("R11", 1'b1, 32'hA0000001);
    sleepReq = 1'b1;
    ctrlStart(6'h0D, 1'b0, 32'hFFFFFFFF);
    cycle();
    check("R11", 1'b0, 32'h0);
    cycle();
    check("R11", 1'b0, 32'h0);
    sleepReq = 1'b0;
    ctrlStart(6'h0D, 1'b0, 32'h12345678);
    cycle();
    check("R11", 1'b0, 32'h0);
    ctrlStart(6'h0E, 1'b1, 32'h0);
    cycle();
    check("R11", 1'b0, 32'h0);
    ctrlStart(6'h0D, 1'b1, 32'h0);
    cycle();
    check("R11", 1'b1, 32'hA0000001);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule